// File: doc/BRIEF.md
# Helper Core Pool Allocator

This block keeps track of a pool of physical processing cores that requesting agents hire as helpers and later hand back. A core that nobody holds is idle, and its power-enable output is low. When a requester strobes a hire request, the allocator picks the lowest-numbered core that is free and not barred from use. It answers with a one-cycle grant pulse that carries the core number, and it raises that core's power enable.

A request that finds no eligible core does not fail. It becomes pending, and the requester's wait line stays high until a core is returned and the request is served. Pending and newly arriving requests compete in round-robin order, and at most one core is handed out per cycle. A returned core goes back to the pool. Returning a core always takes the cycle ahead of handing one out.

Each core can be barred by either of two flag inputs, one for lasting faults and one for temporary exclusion. A barred core is never handed out.

Top module: `corepool_alloc`

## Requirements
- R1: After reset every core is free, and `corePwr`, `waitOut`, `grantValid` and `relErr` are all zero. The round-robin pointer starts at requester 0.
- R2: A requester with a strobe on `reqIn` or a pending request can be served in a cycle in which `relValid` is low and an eligible core exists. If it wins arbitration, bit m of `grantValid` is high for exactly the next cycle.
- R3: During a grant pulse, `grantCore` holds the index of the lowest-numbered core that was free and not barred in the cycle the decision was taken.
- R4: A request that is not served at the edge that follows it makes `waitOut[m]` high from that edge onward. `waitOut[m]` falls in the same cycle that `grantValid[m]` rises, and the two are never high together.
- R5: Among competing requesters, the first one searched upward (wrapping) from the round-robin pointer wins. After a grant, the pointer moves to the winner's index plus one, wrapping.
- R6: In any cycle with `relValid` high, no core is handed out at the following edge. Requests in that cycle become or stay pending.
- R7: A core whose bit is set in `denyFixed` or `denyTemp` is never granted.
- R8: A release names a core with `relCore`. If that core is not currently hired, the release changes no power enable and `relErr` pulses high for one cycle.
- R9: At most one bit of `grantValid` is high in any cycle.
- R10: `corePwr[c]` rises at the edge that grants core c and falls at the edge that takes a valid release of core c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqIn | input | NUM_REQ | One-cycle hire strobe per requester |
| relValid | input | 1 | Release strobe |
| relCore | input | CORE_W | Index of the core being returned |
| denyFixed | input | NUM_CORES | Lasting bar per core |
| denyTemp | input | NUM_CORES | Temporary bar per core |
| waitOut | output | NUM_REQ | Request is pending and unserved |
| grantValid | output | NUM_REQ | One-cycle grant pulse per requester |
| grantCore | output | CORE_W | Granted core index, valid with a grant pulse |
| corePwr | output | NUM_CORES | Power enable, high while the core is hired |
| relErr | output | 1 | Pulse when a release names a free core |

## Verification
The bench builds the block with four cores and three requesters. With those values the pool runs out after a handful of grants, so waiting, serving after a release and round-robin wrap across all requesters all occur within a few dozen cycles. Barring one core out of four makes the skip over a barred index visible in the lowest-index choice. A random phase mixes temporary bars, releases of free and hired cores, and simultaneous requests.

// File: rtl/corepool_pkg.sv
package corepool_pkg;
  typedef struct packed {
    logic grantEn;
    logic relEn;
  } poolStb_t;
endpackage

// File: rtl/pool_ctrl.sv
module pool_ctrl import corepool_pkg::*; #(
  parameter int NUM_REQ = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REQ-1:0] reqIn,
  input  logic               relValid,
  input  logic               freeAvail,
  output poolStb_t           stb,
  output logic [NUM_REQ-1:0] winnerOh,
  output logic [NUM_REQ-1:0] waitOut
);
  localparam int RW = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;

  logic [NUM_REQ-1:0] pending, cand;
  logic [RW-1:0]      rrPtr, winIdx;
  logic               found;

  always_comb begin
    cand     = pending | reqIn;
    winnerOh = '0;
    winIdx   = '0;
    found    = 1'b0;
    for (int k = 0; k < NUM_REQ; k++) begin
      int idx;
      idx = (int'(rrPtr) + k) % NUM_REQ;
      if (!found && cand[idx]) begin
        found         = 1'b1;
        winnerOh[idx] = 1'b1;
        winIdx        = RW'(idx);
      end
    end
    stb.relEn   = relValid;
    stb.grantEn = found && freeAvail && !relValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= '0;
      rrPtr   <= '0;
    end else begin
      pending <= stb.grantEn ? (cand & ~winnerOh) : cand;
      if (stb.grantEn)
        rrPtr <= (int'(winIdx) == NUM_REQ - 1) ? '0 : winIdx + RW'(1);
    end
  end

  assign waitOut = pending;

  // R6: a release cycle never also hands out a core
  a_r6_release_first: assert property (@(posedge clk) disable iff (!rstN)
    relValid |-> !stb.grantEn);
  // R4: a served requester is not left waiting
  a_r4_served_clears: assert property (@(posedge clk) disable iff (!rstN)
    stb.grantEn |=> (waitOut & $past(winnerOh)) == '0);
endmodule

// File: rtl/pool_dp.sv
module pool_dp import corepool_pkg::*; #(
  parameter int NUM_CORES = 8,
  parameter int NUM_REQ   = 4,
  parameter int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  poolStb_t             stb,
  input  logic [NUM_REQ-1:0]   winnerOh,
  input  logic [CORE_W-1:0]    relCore,
  input  logic [NUM_CORES-1:0] denyFixed,
  input  logic [NUM_CORES-1:0] denyTemp,
  output logic                 freeAvail,
  output logic [NUM_REQ-1:0]   grantValid,
  output logic [CORE_W-1:0]    grantCore,
  output logic [NUM_CORES-1:0] corePwr,
  output logic                 relErr
);
  logic [NUM_CORES-1:0] busy, eligible, denied;
  logic [CORE_W-1:0]    freeIdx;
  logic                 relHit;

  assign denied   = denyFixed | denyTemp;
  assign eligible = ~busy & ~denied;

  always_comb begin
    freeAvail = 1'b0;
    freeIdx   = '0;
    for (int c = NUM_CORES - 1; c >= 0; c--) begin
      if (eligible[c]) begin
        freeAvail = 1'b1;
        freeIdx   = CORE_W'(c);
      end
    end
    relHit = 1'b0;
    for (int c = 0; c < NUM_CORES; c++)
      if (int'(relCore) == c && busy[c]) relHit = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy       <= '0;
      grantValid <= '0;
      grantCore  <= '0;
      relErr     <= 1'b0;
    end else begin
      grantValid <= stb.grantEn ? winnerOh : '0;
      relErr     <= stb.relEn && !relHit;
      if (stb.relEn && relHit) busy[relCore] <= 1'b0;
      if (stb.grantEn) begin
        busy[freeIdx] <= 1'b1;
        grantCore     <= freeIdx;
      end
    end
  end

  assign corePwr = busy;

  a_r9_one_grant: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantValid));
  // R7: the chosen core is never barred
  a_r7_not_barred: assert property (@(posedge clk) disable iff (!rstN)
    stb.grantEn |-> !denied[freeIdx]);
  // R10: a granted core is powered during its grant pulse
  a_r10_granted_powered: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid != '0) |-> corePwr[grantCore]);
  // R8: an erroneous release leaves power enables untouched
  a_r8_err_stable: assert property (@(posedge clk) disable iff (!rstN)
    relErr |-> $stable(corePwr));
endmodule

// File: rtl/corepool_alloc.sv
module corepool_alloc import corepool_pkg::*; #(
  parameter int NUM_CORES = 8,
  parameter int NUM_REQ   = 4,
  parameter int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_REQ-1:0]   reqIn,
  input  logic                 relValid,
  input  logic [CORE_W-1:0]    relCore,
  input  logic [NUM_CORES-1:0] denyFixed,
  input  logic [NUM_CORES-1:0] denyTemp,
  output logic [NUM_REQ-1:0]   waitOut,
  output logic [NUM_REQ-1:0]   grantValid,
  output logic [CORE_W-1:0]    grantCore,
  output logic [NUM_CORES-1:0] corePwr,
  output logic                 relErr
);
  poolStb_t           stb;
  logic [NUM_REQ-1:0] winnerOh;
  logic               freeAvail;

  pool_ctrl #(.NUM_REQ(NUM_REQ)) uCtrl (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .relValid(relValid),
    .freeAvail(freeAvail), .stb(stb), .winnerOh(winnerOh), .waitOut(waitOut)
  );

  pool_dp #(.NUM_CORES(NUM_CORES), .NUM_REQ(NUM_REQ), .CORE_W(CORE_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .winnerOh(winnerOh), .relCore(relCore),
    .denyFixed(denyFixed), .denyTemp(denyTemp), .freeAvail(freeAvail),
    .grantValid(grantValid), .grantCore(grantCore), .corePwr(corePwr),
    .relErr(relErr)
  );

  // R4: waiting and being granted are exclusive
  a_r4_wait_vs_grant: assert property (@(posedge clk) disable iff (!rstN)
    (waitOut & grantValid) == '0);
endmodule

// File: tb/corepool_alloc_test.sv
module corepool_alloc_test;
  localparam int NC = 4;
  localparam int NR = 3;
  localparam int CW = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NR-1:0] reqIn = '0;
  logic          relValid = 1'b0;
  logic [CW-1:0] relCore = '0;
  logic [NC-1:0] denyFixed = '0, denyTemp = '0;
  logic [NR-1:0] waitOut, grantValid;
  logic [CW-1:0] grantCore;
  logic [NC-1:0] corePwr;
  logic          relErr;

  corepool_alloc #(.NUM_CORES(NC), .NUM_REQ(NR), .CORE_W(CW)) uut (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .relValid(relValid),
    .relCore(relCore), .denyFixed(denyFixed), .denyTemp(denyTemp),
    .waitOut(waitOut), .grantValid(grantValid), .grantCore(grantCore),
    .corePwr(corePwr), .relErr(relErr)
  );

  always #10 clk = ~clk;

  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  // reference state
  bit [NC-1:0] busyM = '0;
  bit [NR-1:0] pendM = '0, grantM = '0;
  int          coreM = 0, rrM = 0;
  bit          errM = 0;
  bit          prevRel = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic modelStep();
    bit [NR-1:0] cand;
    int w, c;
    cand = pendM | reqIn;
    grantM = '0;
    errM = 0;
    if (relValid) begin
      if (busyM[relCore]) busyM[relCore] = 0; else errM = 1;
      pendM = cand;
    end else begin
      c = -1;
      for (int i = 0; i < NC; i++)
        if (c < 0 && !busyM[i] && !denyFixed[i] && !denyTemp[i]) c = i;
      w = -1;
      for (int k = 0; k < NR; k++)
        if (w < 0 && cand[(rrM + k) % NR]) w = (rrM + k) % NR;
      if (c >= 0 && w >= 0) begin
        grantM[w] = 1;
        coreM = c;
        busyM[c] = 1;
        cand[w] = 0;
        rrM = (w + 1) % NR;
      end
      pendM = cand;
    end
  endtask

  task automatic compareAll();
    chk(waitOut == pendM, "R4 wait", int'(waitOut), int'(pendM));
    chk(grantValid == grantM, "R2 grant", int'(grantValid), int'(grantM));
    if (grantM != '0) begin
      chk(int'(grantCore) == coreM, "R3 core", int'(grantCore), coreM);
      chk(!(denyFixed[grantCore] | denyTemp[grantCore]), "R7 barred", int'(grantCore), -1);
    end
    chk(corePwr == busyM, "R10 power", int'(corePwr), int'(busyM));
    chk(relErr == errM, "R8 err", int'(relErr), int'(errM));
    chk($countones(grantValid) <= 1, "R9 onehot", int'(grantValid), 0);
    if (prevRel) chk(grantValid == '0, "R6 release first", int'(grantValid), 0);
  endtask

  task automatic step(input bit [NR-1:0] r, input bit rv, input int rc);
    reqIn = r;
    relValid = rv;
    relCore = CW'(rc);
    @(posedge clk);
    modelStep();
    prevRel = rv;
    @(negedge clk);
    reqIn = '0;
    relValid = 1'b0;
    compareAll();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      bad++;
      total++;
      $display("FAIL watchdog act=%0d exp=0", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    chk(corePwr == '0 && waitOut == '0 && grantValid == '0 && relErr == 0,
        "R1 reset", int'(corePwr), 0);

    step(3'b001, 0, 0);                    // R2: r0 gets core0
    chk(grantValid == 3'b001 && grantCore == 0, "R2 first hire", int'(grantCore), 0);
    denyFixed = 4'b0010;
    step(3'b110, 0, 0);                    // R5: pointer at 1, r1 wins, core1 barred
    chk(grantValid == 3'b010, "R5 round robin", int'(grantValid), 2);
    chk(grantCore == 2, "R7 skip barred", int'(grantCore), 2);
    chk(waitOut == 3'b100, "R4 loser waits", int'(waitOut), 4);
    step(3'b000, 0, 0);                    // r2 served from pending, core3
    step(3'b001, 0, 0);                    // pool empty, r0 waits
    chk(waitOut == 3'b001, "R4 empty pool", int'(waitOut), 1);
    step(3'b010, 1, 2);                    // R6: release blocks grant
    chk(grantValid == '0, "R6 no grant", int'(grantValid), 0);
    step(3'b000, 0, 0);                    // r0 gets core2
    chk(grantValid == 3'b001 && waitOut == 3'b010, "R5 wrap to r0", int'(grantValid), 1);
    step(3'b000, 1, 1);                    // R8: release of free core
    chk(relErr == 1 && corePwr == 4'b1101, "R8 free release", int'(corePwr), 13);
    step(3'b000, 1, 0);
    step(3'b000, 0, 0);                    // r1 served core0
    chk(grantCore == 0 && corePwr[0], "R10 rehire", int'(grantCore), 0);
    denyFixed = '0;

    for (int n = 0; n < 600; n++) begin
      if (($urandom % 8) == 0) denyTemp = 4'($urandom);
      step(3'($urandom) & 3'($urandom), ($urandom % 3) == 0, int'($urandom % NC));
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule